// File: doc/BRIEF.md
# Accumulator Load and Shift Datapath

This block is the write path into the two 40-bit accumulators of a fixed-point DSP core. Each accumulator has 8 guard bits, a 16-bit high half and a 16-bit low half. On each clock edge where the load strobe is high, a decoded form code picks one of four operand sources: a 16-bit memory word, an 8-bit short immediate, a 16-bit long immediate, or one of the two accumulators. The form code also picks the shift-count source: a signed instruction field, an unsigned instruction field, a temporary register, a fixed count of 16, or the accumulator shift-mode register. The shifted value is written to the selected accumulator.

A sign-extension mode bit controls two things. It decides how a 16-bit operand is widened to 40 bits, and it decides whether a right shift is arithmetic or logical. For the forms that take their count from a field or from the shift-mode register, a left shift that leaves the 40-bit signed range raises a sticky overflow flag on the destination. If the overflow mode bit is also set, the result is clamped to a 32-bit saturation value. Opcode decode, operand fetch and instruction timing sit outside the block.

Top module: `acc_load_shift`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets both accumulators to zero and clears both overflow flags.
- R2: The accumulators change only at a clock edge where `load_en` is high and `form` holds 0..9. Form codes 10..15, or `load_en` low, leave both accumulators unchanged.
- R3: A 16-bit operand enters at bits 15..0. When `sxm`=1, bits 39..16 are copies of bit 15; when `sxm`=0, they are zero. The short immediate is zero-extended to 16 bits before this step.
- R4: Form 2 (memory word) and form 7 (long immediate) shift left by exactly 16. These forms never saturate and never set a flag.
- R5: The form codes select operand and count as follows. Form 0: memory, no shift. Form 1: memory shifted by `treg[5:0]` as a signed count. Form 3: memory shifted by the signed `fshift` (-16..15). Form 4: memory shifted left by the unsigned `ushift` (0..15). Form 5: short immediate, no shift. Form 6: long immediate shifted by `fshift`. Form 8: source accumulator shifted by the signed 5-bit `asm_cnt`. Form 9: source accumulator shifted by `fshift`. A positive count shifts left and a negative count shifts right.
- R6: A right shift is arithmetic when `sxm`=1 and logical when `sxm`=0. This holds for accumulator sources as well.
- R7: In forms 3, 4, 6, 8 and 9, a left-shift result that does not fit in 40-bit two's complement sets the destination's overflow flag. The flag stays set until it is cleared. No other form sets a flag.
- R8: On such an overflow with `ovm`=1, the destination takes 0x007FFFFFFF if the unshifted operand is non-negative and 0xFF80000000 if it is negative. With `ovm`=0, it takes the low 40 bits of the shifted value.
- R9: `dst_sel` selects the destination (0 = accumulator A, 1 = accumulator B), and `src_sel` selects the source accumulator in the same way. In forms 8 and 9 with `dst_given`=0, the result goes back to the source accumulator.
- R10: `ov_clr[0]` clears the flag of accumulator A and `ov_clr[1]` clears the flag of accumulator B. A flag set in the same cycle takes priority over the clear.
- R11: Form 3 with a count of 0 gives the same result as form 0. Form 6 with a count of 0 and a value of 0..255 gives the same result as form 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load strobe |
| form | input | 4 | Decoded load form code |
| dst_sel | input | 1 | Destination accumulator (0 = A, 1 = B) |
| src_sel | input | 1 | Source accumulator for forms 8 and 9 |
| dst_given | input | 1 | Destination explicitly given (forms 8 and 9) |
| mem_word | input | 16 | Data-memory operand |
| short_imm | input | 8 | Short immediate |
| long_imm | input | 16 | Long immediate |
| fshift | input | 5 | Signed field shift count |
| ushift | input | 4 | Unsigned field shift count |
| treg | input | 16 | Temporary register (low 6 bits used) |
| asm_cnt | input | 5 | Accumulator shift-mode count, signed |
| sxm | input | 1 | Sign-extension mode |
| ovm | input | 1 | Overflow (saturation) mode |
| ov_clr | input | 2 | Per-accumulator flag clear |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ov_a | output | 1 | Overflow flag of A |
| ov_b | output | 1 | Overflow flag of B |

## Verification
The assertions check the following on every cycle: the accumulators hold when no valid load occurs, an unshifted memory load is widened correctly, flags are sticky, forms that must not touch a flag leave it alone, and a clear without a competing set takes effect. Other behaviour can only be shown by the bench's sweeps. This covers the shift arithmetic for every count value of every count source, arithmetic versus logical right shifts, the exact overflow boundary with and without saturation, destination routing when no destination is given, and the two equivalences between forms.

// File: rtl/acc_load_shift.sv
module acc_load_shift #(
  parameter int GUARD_W = 8,
  parameter int HALF_W  = 16,
  parameter int SIMM_W  = 8,
  parameter int SHF_W   = 5,
  parameter int USH_W   = 4,
  parameter int TSH_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load_en,
  input  logic [3:0]                      form,
  input  logic                            dst_sel,
  input  logic                            src_sel,
  input  logic                            dst_given,
  input  logic [HALF_W-1:0]               mem_word,
  input  logic [SIMM_W-1:0]               short_imm,
  input  logic [HALF_W-1:0]               long_imm,
  input  logic [SHF_W-1:0]                fshift,
  input  logic [USH_W-1:0]                ushift,
  input  logic [HALF_W-1:0]               treg,
  input  logic [SHF_W-1:0]                asm_cnt,
  input  logic                            sxm,
  input  logic                            ovm,
  input  logic [1:0]                      ov_clr,
  output logic [GUARD_W+2*HALF_W-1:0]     acc_a,
  output logic [GUARD_W+2*HALF_W-1:0]     acc_b,
  output logic                            ov_a,
  output logic                            ov_b
);
  localparam int ACC_W  = GUARD_W + 2*HALF_W;
  localparam int AMT_W  = TSH_W + 1;
  localparam int WIDE_W = ACC_W + 2**(AMT_W-1);
  localparam logic [ACC_W-1:0] NEG_SAT = {{(GUARD_W+1){1'b1}}, {(2*HALF_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] POS_SAT = ~NEG_SAT;

  localparam logic [3:0] F_MEM   = 4'd0;
  localparam logic [3:0] F_MEM_T = 4'd1;
  localparam logic [3:0] F_MEM16 = 4'd2;
  localparam logic [3:0] F_MEM_S = 4'd3;
  localparam logic [3:0] F_MEM_U = 4'd4;
  localparam logic [3:0] F_SIMM  = 4'd5;
  localparam logic [3:0] F_LIM_S = 4'd6;
  localparam logic [3:0] F_LIM16 = 4'd7;
  localparam logic [3:0] F_ACC_M = 4'd8;
  localparam logic [3:0] F_ACC_S = 4'd9;

  logic                    valid, acc_src, sat_form, dst_b, neg, ovf, set_ov;
  logic [HALF_W-1:0]       entry;
  logic [ACC_W-1:0]        operand, src_acc, right_val, result;
  logic signed [AMT_W-1:0] amount;
  logic [AMT_W-1:0]        rsh;
  logic [AMT_W-2:0]        lsh;
  logic [WIDE_W-1:0]       wide;
  logic [WIDE_W-ACC_W:0]   top;

  assign valid    = load_en && (form <= F_ACC_S);
  assign acc_src  = (form == F_ACC_M) || (form == F_ACC_S);
  assign sat_form = (form == F_MEM_S) || (form == F_MEM_U) || (form == F_LIM_S) || acc_src;
  assign dst_b    = (acc_src && !dst_given) ? src_sel : dst_sel;
  assign src_acc  = src_sel ? acc_b : acc_a;

  always_comb begin
    case (form)
      F_SIMM:           entry = {{(HALF_W-SIMM_W){1'b0}}, short_imm};
      F_LIM_S, F_LIM16: entry = long_imm;
      default:          entry = mem_word;
    endcase
  end

  assign operand = acc_src ? src_acc
                           : {{(ACC_W-HALF_W){sxm & entry[HALF_W-1]}}, entry};

  always_comb begin
    case (form)
      F_MEM_T:                   amount = $signed(treg[TSH_W-1:0]);
      F_MEM16, F_LIM16:          amount = AMT_W'(HALF_W);
      F_MEM_S, F_LIM_S, F_ACC_S: amount = {{(AMT_W-SHF_W){fshift[SHF_W-1]}}, fshift};
      F_MEM_U:                   amount = {{(AMT_W-USH_W){1'b0}}, ushift};
      F_ACC_M:                   amount = {{(AMT_W-SHF_W){asm_cnt[SHF_W-1]}}, asm_cnt};
      default:                   amount = '0;
    endcase
  end

  assign neg       = amount[AMT_W-1];
  assign lsh       = amount[AMT_W-2:0];
  assign rsh       = AMT_W'(-amount);
  assign wide      = {{(WIDE_W-ACC_W){operand[ACC_W-1]}}, operand} << lsh;
  assign top       = wide[WIDE_W-1:ACC_W-1];
  assign right_val = sxm ? ACC_W'($signed(operand) >>> rsh) : (operand >> rsh);
  assign ovf       = sat_form && !neg && !((&top) || !(|top));
  assign set_ov    = valid && ovf;

  always_comb begin
    if (neg)             result = right_val;
    else if (ovf && ovm) result = operand[ACC_W-1] ? NEG_SAT : POS_SAT;
    else                 result = wide[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
      ov_a  <= 1'b0;
      ov_b  <= 1'b0;
    end else begin
      if (valid && !dst_b) acc_a <= result;
      if (valid &&  dst_b) acc_b <= result;
      ov_a <= (ov_a & ~ov_clr[0]) | (set_ov & ~dst_b);
      ov_b <= (ov_b & ~ov_clr[1]) | (set_ov &  dst_b);
    end
  end

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;
  always_ff @(posedge clk)
    if (rst_q) assert_reset_clears_R1: assert (acc_a == '0 && acc_b == '0 && !ov_a && !ov_b);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!load_en || form > F_ACC_S) |=> ($stable(acc_a) && $stable(acc_b)));

  assert_mem_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (load_en && form == F_MEM && !dst_sel) |=>
      (acc_a[HALF_W-1:0] == $past(mem_word) &&
       acc_a[ACC_W-1:HALF_W] == {(ACC_W-HALF_W){$past(sxm && mem_word[HALF_W-1])}}));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ov_b && !ov_clr[1]) |=> ov_b);

  assert_no_flag_plain_R7: assert property (@(posedge clk) disable iff (rst)
    (!ov_a && (!load_en || form == F_MEM || form == F_MEM_T || form == F_MEM16 ||
               form == F_SIMM || form == F_LIM16)) |=> !ov_a);

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (ov_clr[0] && !load_en) |=> !ov_a);
endmodule

// File: tb/acc_load_shift_tb.sv
module acc_load_shift_tb;
  logic clk = 0, rst = 1, ld = 0, dsel = 0, ssel = 0, dgiv = 1, sxm = 0, ovm = 0;
  logic [3:0] op = 0;
  logic [15:0] mem = 0, limm = 0, tr = 0;
  logic [7:0] simm = 0;
  logic [4:0] fs = 0, am = 0;
  logic [3:0] fus = 0;
  logic [1:0] clr = 0;
  logic [39:0] acc_a, acc_b;
  logic ov_a, ov_b;
  logic [39:0] ea = 0, eb = 0;
  logic eoa = 0, eob = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_load_shift u_dut (.clk(clk), .rst(rst), .load_en(ld), .form(op), .dst_sel(dsel),
    .src_sel(ssel), .dst_given(dgiv), .mem_word(mem), .short_imm(simm), .long_imm(limm),
    .fshift(fs), .ushift(fus), .treg(tr), .asm_cnt(am), .sxm(sxm), .ovm(ovm),
    .ov_clr(clr), .acc_a(acc_a), .acc_b(acc_b), .ov_a(ov_a), .ov_b(ov_b));

  function automatic logic [40:0] model(input logic [39:0] srcv);
    logic signed [127:0] x, y, maxp, minn;
    logic [15:0] e;
    logic [39:0] v;
    logic ov;
    int amt;
    bit satf;
    maxp = (128'sd1 <<< 39) - 1;
    minn = -(128'sd1 <<< 39);
    case (op)
      4'd5: e = {8'h00, simm};
      4'd6, 4'd7: e = limm;
      default: e = mem;
    endcase
    if (op == 8 || op == 9) x = {{88{srcv[39]}}, srcv};
    else x = sxm ? {{112{e[15]}}, e} : {112'h0, e};
    case (op)
      4'd1: amt = $signed(tr[5:0]);
      4'd2, 4'd7: amt = 16;
      4'd3, 4'd6, 4'd9: amt = $signed(fs);
      4'd4: amt = int'(fus);
      4'd8: amt = $signed(am);
      default: amt = 0;
    endcase
    satf = (op == 3 || op == 4 || op == 6 || op == 8 || op == 9);
    ov = 0;
    if (amt >= 0) begin
      y = x <<< amt;
      v = y[39:0];
      ov = satf && (y > maxp || y < minn);
    end else if (sxm) begin
      y = x >>> (-amt);
      v = y[39:0];
    end else v = x[39:0] >> (-amt);
    if (ov && ovm) v = (x < 0) ? 40'hFF80000000 : 40'h007FFFFFFF;
    return {ov, v};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (acc_a !== ea || acc_b !== eb || ov_a !== eoa || ov_b !== eob) begin
      errors++;
      $display("FAIL %s form=%0d: actual A=%h B=%h oa=%b ob=%b expected A=%h B=%h oa=%b ob=%b",
               tag, op, acc_a, acc_b, ov_a, ov_b, ea, eb, eoa, eob);
    end
  endtask

  task automatic go(input string tag);
    logic [40:0] r;
    logic db;
    r = model(ssel ? eb : ea);
    db = ((op == 8 || op == 9) && !dgiv) ? ssel : dsel;
    eoa = eoa & ~clr[0];
    eob = eob & ~clr[1];
    if (ld && op <= 9) begin
      if (db) begin eb = r[39:0]; eob = eob | r[40]; end
      else    begin ea = r[39:0]; eoa = eoa | r[40]; end
    end
    @(posedge clk); @(negedge clk);
    compare(tag);
    ld = 0; clr = 0;
  endtask

  task automatic do_reset();
    rst = 1; @(posedge clk); @(negedge clk);
    rst = 0; ea = 0; eb = 0; eoa = 0; eob = 0;
    compare("R1");
  endtask

  task automatic load(input logic [3:0] o, input logic d, input string tag);
    op = o; dsel = d; ld = 1; go(tag);
  endtask

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hABCD, 16'h4000};

  initial begin
    logic [39:0] keep;
    @(negedge clk);
    do_reset();
    // R3: widening of memory and short immediate
    for (int s = 0; s < 2; s++) for (int i = 0; i < 8; i++) begin
      sxm = s[0]; mem = vals[i]; load(4'd0, i[0], "R3");
    end
    for (int s = 0; s < 2; s++) for (int k = 0; k < 256; k++) begin
      sxm = s[0]; simm = k[7:0]; load(4'd5, k[0], "R3");
    end
    // R4: fixed shift by 16
    for (int s = 0; s < 2; s++) for (int i = 0; i < 8; i++) begin
      sxm = s[0]; ovm = 1; mem = vals[i]; limm = ~vals[i];
      load(4'd2, 0, "R4"); load(4'd7, 1, "R4");
    end
    // R5/R6: field, unsigned, temporary-register counts
    for (int s = 0; s < 2; s++) for (int m = 0; m < 2; m++) for (int i = 0; i < 8; i++) begin
      sxm = s[0]; ovm = m[0]; mem = vals[i]; limm = vals[7-i];
      for (int c = 0; c < 32; c++) begin
        fs = c[4:0]; load(4'd3, c[0], "R5"); load(4'd6, ~c[0], "R6");
      end
      for (int c = 0; c < 16; c++) begin fus = c[3:0]; load(4'd4, c[1], "R5"); end
      for (int c = 0; c < 64; c++) begin tr = {10'h3A5, c[5:0]}; load(4'd1, c[0], "R6"); end
    end
    // R7/R8/R9: accumulator sources, overflow and saturation
    for (int s = 0; s < 2; s++) for (int m = 0; m < 2; m++) for (int i = 0; i < 8; i++)
      for (int c = 0; c < 32; c++) begin
        sxm = s[0]; ovm = m[0]; limm = vals[i];
        ld = 1; op = 7; dsel = 0; go("R4");
        ld = 1; op = 9; ssel = 0; dgiv = c[1]; dsel = 1; fs = c[4:0]; go("R7");
        ld = 1; op = 8; ssel = 1; dgiv = c[0]; dsel = 0; am = c[4:0]; go("R8");
        clr = 2'b11; go("R10");
      end
    // R9: no destination given writes the source
    sxm = 1; ovm = 0; dgiv = 1;
    mem = 16'h8001; load(4'd0, 0, "R9");
    ld = 1; op = 9; ssel = 0; dsel = 1; dgiv = 0; fs = 5'd1; go("R9");
    ld = 1; op = 8; ssel = 1; dsel = 0; dgiv = 0; am = 5'h1F; go("R9");
    dgiv = 1;
    // R10: set beats clear in the same cycle, clear alone works
    limm = 16'h7FFF; load(4'd7, 0, "R10");
    ld = 1; op = 9; ssel = 0; dsel = 0; fs = 5'd12; clr = 2'b01; go("R10");
    if (!ov_a) begin errors++; $display("FAIL R10 set-vs-clear: actual ov_a=%b expected 1", ov_a); end
    checks++;
    clr = 2'b01; go("R10");
    // R2: strobe low and undefined codes
    mem = 16'h5A5A; op = 0; ld = 0; go("R2");
    for (int o = 10; o < 16; o++) begin load(o[3:0], o[0], "R2"); end
    // R11: equivalences
    for (int s = 0; s < 2; s++) for (int i = 0; i < 8; i++) begin
      sxm = s[0]; mem = vals[i]; fs = 0;
      load(4'd0, 0, "R11"); keep = acc_a;
      load(4'd3, 0, "R11");
      checks++;
      if (acc_a !== keep) begin errors++; $display("FAIL R11 shift0: actual %h expected %h", acc_a, keep); end
    end
    for (int k = 0; k < 256; k++) begin
      sxm = k[1]; simm = k[7:0]; limm = 16'(k); fs = 0;
      load(4'd5, 1, "R11"); keep = acc_b;
      load(4'd6, 1, "R11");
      checks++;
      if (acc_b !== keep) begin errors++; $display("FAIL R11 short: actual %h expected %h", acc_b, keep); end
    end
    // R1: reset after activity
    ov_clr_dummy();
    do_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic ov_clr_dummy();
    limm = 16'h7FFF; load(4'd7, 1, "R1");
    ld = 1; op = 9; ssel = 1; dsel = 1; fs = 5'd15; go("R1");
  endtask

  initial begin
    #1_800_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule